// File: doc/BRIEF.md
# Transmit descriptor gather walker

The walker turns one transmit frame descriptor into an ordered stream of buffer read requests. A caller hands it the base of a descriptor ring and a slot number. The walker reads the 128-byte descriptor word by word from a descriptor memory with a fixed one-cycle read latency. It takes the buffer count from the header and then decodes the packed 6-byte buffer entries one at a time. For each entry it offers a 36-bit buffer address and a 12-bit length on a valid/ready request port.

Every buffer is checked before its request is issued. A bad count drops the whole descriptor. A buffer that is too long, or that would push the frame past its size limit, stops the frame at that buffer. A one-cycle done pulse closes every descriptor, whether it finished cleanly or not. At that point the error flags and the byte total of the issued buffers are valid. The flags hold until the next descriptor is accepted.

Top module: `tx_gather_walker`

## Requirements
- R1: The descriptor for slot s in a ring whose base is B (given in 256-byte units) is read from byte address B*256 + s*128, word-aligned, one 32-bit little-endian word per read.
- R2: The buffer count is bits 4:0 of descriptor byte 3. Bits 7:5 of that byte and bytes 0 to 2 have no effect on the requests.
- R3: Entry i starts at descriptor byte 4+6*i. Its first four bytes are address bits 31:0, little-endian. The following 16-bit little-endian word carries address bits 35:32 in bits 3:0 and the buffer length in bits 15:4. Entries at odd i start on a 2-byte offset and decode the same way.
- R4: Requests are issued in ascending entry order, one per entry. While req_valid_o is high and req_ready_i is low, the request stays valid and its address and length stay unchanged.
- R5: A count of 0 or of more than 20 sets err_cnt_o, and no request is issued for that descriptor.
- R6: A buffer length above 4092 sets err_len_o. No request is issued for that buffer or any later one. The requests before it are still issued.
- R7: If a buffer would bring the running frame total above 8192 bytes, that buffer is handled as in R6. A total of exactly 8192 is accepted.
- R8: done_o is a one-cycle pulse that follows the handshake of the last issued request, or follows the error that ended the descriptor. While it is high, frame_len_o equals the sum of the lengths of the issued requests.
- R9: err_cnt_o and err_len_o stay set after done_o until the next descriptor is accepted, and are cleared at that acceptance.
- R10: After reset, start_ready_o is 1 and req_valid_o, done_o, err_cnt_o and err_len_o are 0. start_ready_o is high only while no descriptor is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Request to walk one descriptor |
| start_ready_o | output | 1 | Walker idle; start is accepted on valid and ready |
| ring_base_i | input | 28 | Ring base address, bits 35:8 |
| slot_i | input | 8 | Descriptor slot in the ring |
| mem_rd_o | output | 1 | Descriptor memory read strobe |
| mem_addr_o | output | 36 | Byte address of the word to read |
| mem_rdata_i | input | 32 | Read word, valid the cycle after the strobe |
| req_valid_o | output | 1 | Buffer request valid |
| req_ready_i | input | 1 | Buffer request accepted |
| req_addr_o | output | 36 | Buffer start address |
| req_len_o | output | 12 | Buffer length in bytes |
| done_o | output | 1 | One-cycle end-of-descriptor pulse |
| frame_len_o | output | 14 | Sum of issued buffer lengths |
| err_cnt_o | output | 1 | Buffer count out of range |
| err_len_o | output | 1 | Buffer or frame length limit exceeded |

## Verification
The assertions take two things for granted. First, the descriptor memory returns the addressed word exactly one cycle after mem_rd_o. Second, ring_base_i and slot_i are valid in the cycle a start is accepted. The bench memory model is a registered word store that answers every strobe on the next edge. The bench drives the start fields together with start_valid_i and holds them until acceptance. req_ready_i is left unconstrained: it is driven either constantly high or from a pseudo-random bit sequence. This lets the stall-stability property meet long and short back-pressure runs.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;
  localparam int ADDR_W       = 36;
  localparam int WORD_W       = 32;
  localparam int LEN_W        = 12;
  localparam int HI_ADDR_W    = ADDR_W - WORD_W;
  localparam int RING_ALIGN_W = 8;
  localparam int CNT_FIELD_W  = 5;
  localparam int CNT_BYTE     = 3;
  localparam int ENTRY_BASE   = 4;
  localparam int ENTRY_BYTES  = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } buf_req_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_RD,
    ST_HDR_CHK,
    ST_ENT_LO,
    ST_ENT_HI,
    ST_ENT_CHK,
    ST_REQ,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/tx_gather_addr.sv
module tx_gather_addr
  import tx_gather_pkg::*;
#(
  parameter int SLOT_W     = 8,
  parameter int DESC_BYTES = 128,
  localparam int DESC_SH   = $clog2(DESC_BYTES),
  localparam int WSEL_W    = DESC_SH - 2
) (
  input  logic [ADDR_W-RING_ALIGN_W-1:0] ring_base_i,
  input  logic [SLOT_W-1:0]              slot_i,
  input  logic [WSEL_W-1:0]              word_i,
  output logic [ADDR_W-1:0]              addr_o
);
  logic [ADDR_W-1:0] ring_addr, slot_off, word_off;

  // ring base is only 256-byte aligned, so slot offset must be added, not ORed
  assign ring_addr = {ring_base_i, {RING_ALIGN_W{1'b0}}};
  assign slot_off  = ADDR_W'(slot_i) << DESC_SH;
  assign word_off  = ADDR_W'(word_i) << 2;
  assign addr_o    = ring_addr + slot_off + word_off;
endmodule

// File: rtl/tx_gather_unpack.sv
module tx_gather_unpack
  import tx_gather_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic              half_i,
  output buf_req_t          ent_o
);
  logic [WORD_W-1:0] lo_addr;
  logic [15:0]       hi_word;

  // entry starts at byte 0 of w0 (even index) or byte 2 of w0 (odd index)
  always_comb begin
    if (half_i) begin
      lo_addr = {w1_i[15:0], w0_i[31:16]};
      hi_word = w1_i[31:16];
    end else begin
      lo_addr = w0_i;
      hi_word = w1_i[15:0];
    end
    ent_o.addr = {hi_word[HI_ADDR_W-1:0], lo_addr};
    ent_o.len  = hi_word[15:HI_ADDR_W];
  end
endmodule

// File: rtl/tx_gather_len_chk.sv
module tx_gather_len_chk
  import tx_gather_pkg::*;
#(
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  localparam int TOT_W      = $clog2(MAX_FRAME + (1 << LEN_W))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] chk_len_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] add_len_i,
  output logic             bad_o,
  output logic [TOT_W-1:0] total_o
);
  logic [TOT_W-1:0] total_q;
  logic [TOT_W:0]   next_sum;

  assign next_sum = {1'b0, total_q} + (TOT_W+1)'(chk_len_i);
  assign bad_o    = (32'(chk_len_i) > MAX_BUF_LEN) || (32'(next_sum) > MAX_FRAME);
  assign total_o  = total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    total_q <= '0;
    else if (clr_i) total_q <= '0;
    else if (add_i) total_q <= total_q + TOT_W'(add_len_i);
  end

  p_frame_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(total_q) <= MAX_FRAME);
endmodule

// File: rtl/tx_gather_walker.sv
module tx_gather_walker
  import tx_gather_pkg::*;
#(
  parameter int SLOT_W      = 8,
  parameter int DESC_BYTES  = 128,
  parameter int MAX_BUFS    = 20,
  parameter int MAX_BUF_LEN = 4092,
  parameter int MAX_FRAME   = 8192,
  localparam int OFF_W      = $clog2(DESC_BYTES),
  localparam int WSEL_W     = OFF_W - 2,
  localparam int TOT_W      = $clog2(MAX_FRAME + (1 << LEN_W)),
  localparam int BASE_W     = ADDR_W - RING_ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic [BASE_W-1:0] ring_base_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              done_o,
  output logic [TOT_W-1:0]  frame_len_o,
  output logic              err_cnt_o,
  output logic              err_len_o
);
  walk_state_e            state_q;
  logic [BASE_W-1:0]      base_q;
  logic [SLOT_W-1:0]      slot_q;
  logic [CNT_FIELD_W-1:0] cnt_q, idx_q, hdr_cnt;
  logic [WORD_W-1:0]      lo_word_q;
  buf_req_t               req_q, ent;
  logic                   err_cnt_q, err_len_q;
  logic [OFF_W-1:0]       ent_off;
  logic [WSEL_W-1:0]      word_sel;
  logic                   accept, req_fire, ent_bad, last_ent;

  assign accept   = start_valid_i && start_ready_o;
  assign req_fire = req_valid_o && req_ready_i;
  assign hdr_cnt  = mem_rdata_i[8*CNT_BYTE +: CNT_FIELD_W];
  assign ent_off  = OFF_W'(ENTRY_BASE) + OFF_W'(idx_q) * OFF_W'(ENTRY_BYTES);
  assign last_ent = (idx_q + 1'b1) == cnt_q;

  always_comb begin
    unique case (state_q)
      ST_ENT_LO: word_sel = ent_off[OFF_W-1:2];
      ST_ENT_HI: word_sel = ent_off[OFF_W-1:2] + 1'b1;
      default:   word_sel = '0;
    endcase
  end

  assign mem_rd_o = (state_q == ST_HDR_RD) || (state_q == ST_ENT_LO) ||
                    (state_q == ST_ENT_HI);

  tx_gather_addr #(.SLOT_W(SLOT_W), .DESC_BYTES(DESC_BYTES)) u_addr (
    .ring_base_i (base_q),
    .slot_i      (slot_q),
    .word_i      (word_sel),
    .addr_o      (mem_addr_o)
  );

  tx_gather_unpack u_unpack (
    .w0_i   (lo_word_q),
    .w1_i   (mem_rdata_i),
    .half_i (ent_off[1]),
    .ent_o  (ent)
  );

  tx_gather_len_chk #(.MAX_BUF_LEN(MAX_BUF_LEN), .MAX_FRAME(MAX_FRAME)) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .chk_len_i (ent.len),
    .add_i     (req_fire),
    .add_len_i (req_q.len),
    .bad_o     (ent_bad),
    .total_o   (frame_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      slot_q    <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      lo_word_q <= '0;
      req_q     <= '0;
      err_cnt_q <= 1'b0;
      err_len_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          base_q    <= ring_base_i;
          slot_q    <= slot_i;
          err_cnt_q <= 1'b0;
          err_len_q <= 1'b0;
          state_q   <= ST_HDR_RD;
        end
        ST_HDR_RD: state_q <= ST_HDR_CHK;
        ST_HDR_CHK: begin
          idx_q <= '0;
          cnt_q <= hdr_cnt;
          if (hdr_cnt == '0 || 32'(hdr_cnt) > MAX_BUFS) begin
            err_cnt_q <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            state_q <= ST_ENT_LO;
          end
        end
        ST_ENT_LO: state_q <= ST_ENT_HI;
        ST_ENT_HI: begin
          lo_word_q <= mem_rdata_i;
          state_q   <= ST_ENT_CHK;
        end
        ST_ENT_CHK: begin
          if (ent_bad) begin
            err_len_q <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            req_q   <= ent;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (req_ready_i) begin
          idx_q   <= idx_q + 1'b1;
          state_q <= last_ent ? ST_DONE : ST_ENT_LO;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ready_o = (state_q == ST_IDLE);
  assign req_valid_o   = (state_q == ST_REQ);
  assign req_addr_o    = req_q.addr;
  assign req_len_o     = req_q.len;
  assign done_o        = (state_q == ST_DONE);
  assign err_cnt_o     = err_cnt_q;
  assign err_len_o     = err_len_q;

  p_req_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

  p_no_req_on_cnt_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o |-> !req_valid_o);

  p_buf_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> 32'(req_len_o) <= MAX_BUF_LEN);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(err_cnt_o) && $stable(err_len_o));

  p_busy_after_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_i && start_ready_o |=> !start_ready_o);

  p_ready_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ready_o |-> !req_valid_o && !mem_rd_o);
endmodule

// File: tb/tb_tx_gather_walker.sv
module tb_tx_gather_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_valid_i = 1'b0;
  logic        start_ready_o;
  logic [27:0] ring_base_i = '0;
  logic [7:0]  slot_i = '0;
  logic        mem_rd_o;
  logic [35:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b1;
  logic [35:0] req_addr_o;
  logic [11:0] req_len_o;
  logic        done_o;
  logic [13:0] frame_len_o;
  logic        err_cnt_o, err_len_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tx_gather_walker dut (
    .clk_i, .rst_ni, .start_valid_i, .start_ready_o, .ring_base_i, .slot_i,
    .mem_rd_o, .mem_addr_o, .mem_rdata_i, .req_valid_o, .req_ready_i,
    .req_addr_o, .req_len_o, .done_o, .frame_len_o, .err_cnt_o, .err_len_o
  );

  logic [31:0] dmem [logic [35:0]];
  always @(posedge clk_i)
    if (mem_rd_o) mem_rdata_i <= dmem.exists(mem_addr_o) ? dmem[mem_addr_o] : 32'h0;

  int checks = 0, bad = 0, cyc = 0;
  logic        stall_en = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic [35:0] e_addr [0:23];
  logic [11:0] e_len  [0:23];
  logic [35:0] got_addr [0:31];
  logic [11:0] got_len  [0:31];
  int          got_n = 0;

  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready_i = stall_en ? lfsr[0] : 1'b1;
    if (req_valid_o && req_ready_i && got_n < 32) begin
      got_addr[got_n] = req_addr_o;
      got_len[got_n]  = req_len_o;
      got_n++;
    end
    cyc++;
    if (cyc > WATCHDOG) begin
      bad++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [35:0] a, logic [7:0] b);
    logic [35:0] wa = {a[35:2], 2'b00};
    logic [31:0] w  = dmem.exists(wa) ? dmem[wa] : 32'h0;
    w[8*a[1:0] +: 8] = b;
    dmem[wa] = w;
  endtask

  // header byte 3 = count byte, entry i at 4+6i: addr[31:0] LE, then {len, addr[35:32]} LE
  task automatic make_desc(logic [27:0] base, logic [7:0] slot, logic [7:0] cnt_byte, int n);
    logic [35:0] d = {base, 8'h00} + 36'(slot) * 36'd128;
    wr_byte(d, 8'hAA); wr_byte(d + 1, 8'h55); wr_byte(d + 2, 8'hFF);
    wr_byte(d + 3, cnt_byte);
    for (int i = 0; i < n; i++) begin
      logic [35:0] o  = d + 36'(4 + 6 * i);
      logic [15:0] hi = {e_len[i], e_addr[i][35:32]};
      for (int k = 0; k < 4; k++) wr_byte(o + 36'(k), e_addr[i][8*k +: 8]);
      wr_byte(o + 4, hi[7:0]);
      wr_byte(o + 5, hi[15:8]);
    end
  endtask

  task automatic run(string tag, logic [27:0] base, logic [7:0] slot, int exp_n,
                     logic exp_ce, logic exp_le, int exp_tot);
    got_n = 0;
    @(negedge clk_i);
    ring_base_i = base; slot_i = slot; start_valid_i = 1'b1;
    @(negedge clk_i);
    start_valid_i = 1'b0;
    chk({tag, " R10 busy"}, start_ready_o, 1'b0);
    for (int t = 0; t < 3000; t++) begin
      if (done_o) break;
      @(negedge clk_i);
    end
    chk({tag, " R8 done"}, done_o, 1'b1);
    chk({tag, " R4 req count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk({tag, " R3 addr"}, got_addr[i], e_addr[i]);
      chk({tag, " R3 len"}, got_len[i], e_len[i]);
    end
    chk({tag, " R5 err_cnt"}, err_cnt_o, exp_ce);
    chk({tag, " R6 err_len"}, err_len_o, exp_le);
    chk({tag, " R8 frame_len"}, frame_len_o, exp_tot);
    @(negedge clk_i);
    chk({tag, " R8 single pulse"}, done_o, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10 reset start_ready", start_ready_o, 1'b1);
    chk("R10 reset req_valid", req_valid_o, 1'b0);
    chk("R10 reset done", done_o, 1'b0);
    chk("R10 reset errs", {err_cnt_o, err_len_o}, 2'b00);
  endtask

  task automatic t_basic;  // R1 R2 R3 odd entry on 2-byte offset
    e_addr[0] = 36'hA_1234_5670; e_len[0] = 12'd100;
    e_addr[1] = 36'h3_0000_0004; e_len[1] = 12'd4092;
    e_addr[2] = 36'hF_FFFF_FFF0; e_len[2] = 12'd1;
    make_desc(28'h0000123, 8'd5, 8'd3, 3);
    run("basic", 28'h0000123, 8'd5, 3, 1'b0, 1'b0, 4193);
  endtask

  task automatic t_pad_bits;  // R2: bits 7:5 of count byte ignored
    e_addr[0] = 36'h0_DEAD_BEE0; e_len[0] = 12'd64;
    e_addr[1] = 36'h5_0102_0304; e_len[1] = 12'd2048;
    make_desc(28'h0ABCDE0, 8'd77, 8'hE2, 2);
    run("pad R2", 28'h0ABCDE0, 8'd77, 2, 1'b0, 1'b0, 2112);
  endtask

  task automatic t_max_stall;  // R4 with back-pressure, 20 entries, top slot
    for (int i = 0; i < 20; i++) begin
      e_addr[i] = {4'(i), 32'h1000_0000 + 32'(i * 32'h0101_0101)};
      e_len[i]  = 12'd400;
    end
    make_desc(28'hFFFFF00, 8'd255, 8'd20, 20);
    stall_en = 1'b1;
    run("max20 stall R4", 28'hFFFFF00, 8'd255, 20, 1'b0, 1'b0, 8000);
    stall_en = 1'b0;
  endtask

  task automatic t_cnt_bad;  // R5
    e_addr[0] = 36'h1_1111_1110; e_len[0] = 12'd8;
    make_desc(28'h0000400, 8'd9, 8'd0, 1);
    run("cnt0 R5", 28'h0000400, 8'd9, 0, 1'b1, 1'b0, 0);
    make_desc(28'h0000400, 8'd10, 8'd21, 1);
    run("cnt21 R5", 28'h0000400, 8'd10, 0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_buf_long;  // R6
    e_addr[0] = 36'h2_0000_0100; e_len[0] = 12'd10;
    e_addr[1] = 36'h2_0000_0200; e_len[1] = 12'd4093;
    e_addr[2] = 36'h2_0000_0300; e_len[2] = 12'd5;
    make_desc(28'h0000800, 8'd1, 8'd3, 3);
    run("buflong R6", 28'h0000800, 8'd1, 1, 1'b0, 1'b1, 10);
  endtask

  task automatic t_frame_limit;  // R7 and R9
    e_addr[0] = 36'h4_0000_0000; e_len[0] = 12'd4092;
    e_addr[1] = 36'h4_0000_2000; e_len[1] = 12'd4092;
    e_addr[2] = 36'h4_0000_4000; e_len[2] = 12'd8;
    make_desc(28'h0001000, 8'd2, 8'd3, 3);
    run("exact8192 R7", 28'h0001000, 8'd2, 3, 1'b0, 1'b0, 8192);
    e_len[2] = 12'd9;
    make_desc(28'h0001000, 8'd3, 8'd3, 3);
    run("over8192 R7", 28'h0001000, 8'd3, 2, 1'b0, 1'b1, 8184);
    repeat (5) @(negedge clk_i);
    chk("R9 err_len held while idle", err_len_o, 1'b1);
    @(negedge clk_i);
    ring_base_i = 28'h0001000; slot_i = 8'd2; start_valid_i = 1'b1;
    @(negedge clk_i);
    start_valid_i = 1'b0;
    chk("R9 err_len cleared on accept", err_len_o, 1'b0);
    for (int t = 0; t < 3000; t++) begin
      if (done_o) break;
      @(negedge clk_i);
    end
    chk("R9 clean frame after error", {done_o, err_len_o, err_cnt_o}, 3'b100);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_basic;
    t_pad_bits;
    t_max_stall;
    t_cnt_bad;
    t_buf_long;
    t_frame_limit;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule